// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block handles the hardware handshake lines beside a UART transmitter. In manual mode a configuration bit sets the RTS line directly. In automatic mode the block asserts RTS around each burst of transmit data. It waits a programmable lead delay before it allows the serializer to start, and it holds RTS for a programmable trail delay after the line goes quiet. This timing fits a half-duplex line driver whose enable must wrap the frame. The CTS input is synchronized and can gate the transmit permit. The polarity of RTS and of CTS can each be set. The serializer is not part of this block.

The delays count either clock cycles or bit ticks, set by a configuration bit. If new data arrives while RTS is being held after a burst, the block goes back to transmitting and RTS stays asserted. Each change of the synchronized CTS level gives a one-cycle event pulse, which feeds the modem-status interrupt logic.

Top module: `rts_cts_ctrl`

## Requirements
- R1: While reset is held, and with `cfg` at zero, `rts_pin` is 0, `tx_permit` is 1 and `cts_change` is 0. The sequencer starts in the idle state.
- R2: When `cfg[0]` (automatic mode) is 0, the internal RTS level equals `cfg[1]` in the same cycle. With CTS gating off, `tx_permit` is 1.
- R3: When `cfg[4]` is 1, `rts_pin` is the inverse of the internal asserted RTS level. When `cfg[4]` is 0, `rts_pin` equals that level.
- R4: In automatic mode the first cycle with `tx_has_data` high in idle asserts RTS from the next clock. `tx_permit` rises only after `lead_dly` delay units have passed.
- R5: When `cfg[2]` is 1, one delay unit is a cycle with `bit_tick` high. When `cfg[2]` is 0, one delay unit is every clock cycle.
- R6: After the transmit-done condition, RTS stays asserted for `trail_dly` delay units and is then released. `tx_permit` is low during this time.
- R7: If `tx_has_data` goes high while RTS is being held after a burst, the block returns to transmitting on the next clock and RTS never drops.
- R8: A `lead_dly` of 0 allows transmission on the clock after data appears. A `trail_dly` of 0 releases RTS on the clock after the transmit-done condition.
- R9: When `cfg[5]` is 1, `tx_permit` is 0 whenever the synchronized CTS level is inactive. CTS is active high when `cfg[6]` is 0 and active low when `cfg[6]` is 1. It passes through two synchronizer flops.
- R10: `cts_change` is a one-cycle pulse for each change of the synchronized CTS level, whatever the configuration.
- R11: When `cfg[7]` is 1 in automatic mode, RTS stays asserted while the sequencer is idle.
- R12: Clearing `cfg[0]` returns the sequencer to idle on the next clock, from any state.
- R13: The transmit-done condition is `tx_has_data` low together with `tx_idle` high. When `cfg[3]` is 1, `tx_has_data` low alone is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg | input | 8 | Handshake configuration bits (see requirements) |
| lead_dly | input | DLY_W | Delay units between RTS assertion and permit |
| trail_dly | input | DLY_W | Delay units that RTS is held after transmit-done |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_has_data | input | 1 | Transmitter has data waiting |
| tx_idle | input | 1 | Serializer has finished shifting |
| cts_pin | input | 1 | Asynchronous CTS line |
| rts_pin | output | 1 | RTS line, after polarity |
| tx_permit | output | 1 | Serializer may start a character |
| cts_change | output | 1 | Pulse on each synchronized CTS change |

## Verification
The handshake is run with several patterns. Clock-unit and tick-unit delays separate the two delay bases. Non-zero and zero lead and trail values check that the counter is loaded and that the zero case skips the wait. A burst that restarts inside the trail window shows that RTS is kept asserted. An early-trail burst, where data ends before the serializer is idle, shows which transmit-done condition is in use. CTS is toggled with each polarity, with gating on and off, to separate the permit gating from the change pulse. Automatic mode is cleared in the middle of a lead phase to show the forced return to idle.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int CFG_W         = 8;
  localparam int CB_AUTO       = 0;
  localparam int CB_MAN_RTS    = 1;
  localparam int CB_TICK_UNIT  = 2;
  localparam int CB_EARLY_TRL  = 3;
  localparam int CB_RTS_INV    = 4;
  localparam int CB_CTS_GATE   = 5;
  localparam int CB_CTS_INV    = 6;
  localparam int CB_HOLD       = 7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_TRAIL  = 2'd3
  } rfc_state_e;
endpackage

// File: rtl/rfc_rst_sync.sv
module rfc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rfc_cts_sync.sv
module rfc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_pin,
  output logic cts_lvl,
  output logic cts_change
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], cts_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign cts_lvl    = sh_q[STAGES-1];
  assign cts_change = sh_q[STAGES] ^ sh_q[STAGES-1];

  AST_CHANGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cts_change && (sh_q[STAGES-1] == sh_q[STAGES-2]) |=> !cts_change); // R10
endmodule

// File: rtl/rfc_delay_cnt.sv
module rfc_delay_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q <= ONE);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0); // R4
  AST_LOAD_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && dec)); // R6
endmodule

// File: rtl/rfc_seq.sv
module rfc_seq
  import rfc_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             tick_unit,
  input  logic             early_trail,
  input  logic             bit_tick,
  input  logic             tx_has_data,
  input  logic             tx_idle,
  input  logic [DLY_W-1:0] lead_val,
  input  logic [DLY_W-1:0] trail_val,
  input  logic             cnt_last,
  output logic             cnt_load,
  output logic [DLY_W-1:0] cnt_load_val,
  output logic             cnt_dec,
  output rfc_state_e       state
);
  localparam logic [DLY_W-1:0] ZERO = '0;

  rfc_state_e state_d;
  logic       unit;
  logic       tx_done;

  always_comb begin
    unit         = tick_unit ? bit_tick : 1'b1;
    tx_done      = !tx_has_data && (early_trail || tx_idle);
    state_d      = state;
    cnt_load     = 1'b0;
    cnt_load_val = lead_val;
    cnt_dec      = 1'b0;
    if (!auto_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tx_has_data) begin
            if (lead_val == ZERO) begin
              state_d = ST_ACTIVE;
            end else begin
              state_d  = ST_LEAD;
              cnt_load = 1'b1;
            end
          end
        end
        ST_LEAD: begin
          if (unit) begin
            if (cnt_last) state_d = ST_ACTIVE;
            else          cnt_dec = 1'b1;
          end
        end
        ST_ACTIVE: begin
          cnt_load_val = trail_val;
          if (tx_done) begin
            if (trail_val == ZERO) begin
              state_d = ST_IDLE;
            end else begin
              state_d  = ST_TRAIL;
              cnt_load = 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (tx_has_data) begin
            state_d = ST_ACTIVE;
          end else if (unit) begin
            if (cnt_last) state_d = ST_IDLE;
            else          cnt_dec = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  AST_LEAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && state == ST_IDLE && tx_has_data |=> state != ST_IDLE); // R4
  AST_TRAIL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && state == ST_TRAIL && tx_has_data |=> state == ST_ACTIVE); // R7
  AST_AUTO_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> state == ST_IDLE); // R12
endmodule

// File: rtl/rts_cts_ctrl.sv
module rts_cts_ctrl
  import rfc_pkg::*;
#(
  parameter int DLY_W      = 8,
  parameter int CTS_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic [DLY_W-1:0] lead_dly,
  input  logic [DLY_W-1:0] trail_dly,
  input  logic             bit_tick,
  input  logic             tx_has_data,
  input  logic             tx_idle,
  input  logic             cts_pin,
  output logic             rts_pin,
  output logic             tx_permit,
  output logic             cts_change
);
  logic             srst_n;
  logic             cts_lvl;
  logic             cts_act;
  logic             cts_ok;
  logic             rts_int;
  logic             cnt_last;
  logic             cnt_load;
  logic             cnt_dec;
  logic [DLY_W-1:0] cnt_load_val;
  rfc_state_e       state;

  rfc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rfc_cts_sync #(.STAGES(CTS_STAGES)) u_cts (
    .clk        (clk),
    .rst_n      (srst_n),
    .cts_pin    (cts_pin),
    .cts_lvl    (cts_lvl),
    .cts_change (cts_change)
  );

  rfc_delay_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  rfc_seq #(.DLY_W(DLY_W)) u_seq (
    .clk          (clk),
    .rst_n        (srst_n),
    .auto_en      (cfg[CB_AUTO]),
    .tick_unit    (cfg[CB_TICK_UNIT]),
    .early_trail  (cfg[CB_EARLY_TRL]),
    .bit_tick     (bit_tick),
    .tx_has_data  (tx_has_data),
    .tx_idle      (tx_idle),
    .lead_val     (lead_dly),
    .trail_val    (trail_dly),
    .cnt_last     (cnt_last),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cnt_dec      (cnt_dec),
    .state        (state)
  );

  always_comb begin
    cts_act = cts_lvl ^ cfg[CB_CTS_INV];
    cts_ok  = !cfg[CB_CTS_GATE] || cts_act;
    if (cfg[CB_AUTO]) begin
      rts_int   = (state != ST_IDLE) || cfg[CB_HOLD];
      tx_permit = (state == ST_ACTIVE) && cts_ok;
    end else begin
      rts_int   = cfg[CB_MAN_RTS];
      tx_permit = cts_ok;
    end
    rts_pin = rts_int ^ cfg[CB_RTS_INV];
  end

  AST_RTS_COVERS_PERMIT: assert property (@(posedge clk) disable iff (!srst_n)
    cfg[CB_AUTO] && tx_permit |-> (rts_pin ^ cfg[CB_RTS_INV])); // R4
  AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!srst_n)
    cfg[CB_CTS_GATE] && !(cts_lvl ^ cfg[CB_CTS_INV]) |-> !tx_permit); // R9
  AST_TRAIL_NO_PERMIT: assert property (@(posedge clk) disable iff (!srst_n)
    cfg[CB_AUTO] && state == ST_TRAIL |-> !tx_permit); // R6
endmodule

// File: tb/rts_cts_ctrl_tb.sv
module rts_cts_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] cfg;
  logic [7:0] lead_dly;
  logic [7:0] trail_dly;
  logic       bit_tick;
  logic       tx_has_data;
  logic       tx_idle;
  logic       cts_pin;
  logic       rts_pin;
  logic       tx_permit;
  logic       cts_change;

  int    n_checks;
  int    n_errors;
  string tag;
  int    tick_div;
  int    tick_cnt;
  bit    done;

  // reference model state
  bit m_r1, m_r2;
  bit m_s1, m_s2, m_s3;
  int m_st;
  int m_cnt;

  rts_cts_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .lead_dly    (lead_dly),
    .trail_dly   (trail_dly),
    .bit_tick    (bit_tick),
    .tx_has_data (tx_has_data),
    .tx_idle     (tx_idle),
    .cts_pin     (cts_pin),
    .rts_pin     (rts_pin),
    .tx_permit   (tx_permit),
    .cts_change  (cts_change)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // bit tick generator: one pulse every tick_div cycles
  always @(negedge clk) begin
    #1;
    if (tick_div > 0) begin
      if (tick_cnt >= tick_div - 1) begin
        tick_cnt = 0;
        bit_tick = 1'b1;
      end else begin
        tick_cnt++;
        bit_tick = 1'b0;
      end
    end else begin
      bit_tick = 1'b0;
    end
  end

  // behavioural reference model, updated on each rising edge
  always @(posedge clk) begin
    bit unit;
    bit done_c;
    if (!m_r2) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_st = 0; m_cnt = 0;
    end else begin
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts_pin;
      unit   = cfg[2] ? bit_tick : 1'b1;
      done_c = !tx_has_data && (cfg[3] || tx_idle);
      if (!cfg[0]) m_st = 0;
      else begin
        case (m_st)
          0: if (tx_has_data) begin
               if (lead_dly == 0) m_st = 2;
               else begin m_st = 1; m_cnt = lead_dly; end
             end
          1: if (unit) begin
               if (m_cnt <= 1) m_st = 2; else m_cnt--;
             end
          2: if (done_c) begin
               if (trail_dly == 0) m_st = 0;
               else begin m_st = 3; m_cnt = trail_dly; end
             end
          default: if (tx_has_data) m_st = 2;
                   else if (unit) begin
                     if (m_cnt <= 1) m_st = 0; else m_cnt--;
                   end
        endcase
      end
    end
    if (!rst_n) begin m_r1 = 0; m_r2 = 0; end
    else begin m_r2 = m_r1; m_r1 = 1; end
  end

  // compare on every falling edge, before inputs move
  always @(negedge clk) begin
    bit e_int, e_rts, e_ok, e_perm, e_chg;
    if (rst_n && !done) begin
      e_ok  = !cfg[5] || (m_s2 ^ cfg[6]);
      e_int = cfg[0] ? (m_st != 0 || cfg[7]) : cfg[1];
      e_rts = e_int ^ cfg[4];
      e_perm = cfg[0] ? (m_st == 2 && e_ok) : e_ok;
      e_chg = m_s2 ^ m_s3;
      chk(rts_pin === e_rts, tag, "rts_pin", int'(rts_pin), int'(e_rts));
      chk(tx_permit === e_perm, tag, "tx_permit", int'(tx_permit), int'(e_perm));
      chk(cts_change === e_chg, tag, "cts_change", int'(cts_change), int'(e_chg));
    end
  end

  task automatic burst(input int busy, input int drain, input int tail);
    tx_has_data = 1'b1; tx_idle = 1'b0;
    step(busy);
    tx_has_data = 1'b0;
    step(drain);
    tx_idle = 1'b1;
    step(tail);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 0;
    tag = "R1";
    rst_n = 1'b0; cfg = 8'h00; lead_dly = 8'd0; trail_dly = 8'd0;
    tx_has_data = 1'b0; tx_idle = 1'b1; cts_pin = 1'b0;
    tick_div = 0; tick_cnt = 0; bit_tick = 1'b0;
    m_r1 = 0; m_r2 = 0; m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    step(3);
    chk(rts_pin === 1'b0, "R1", "reset rts_pin", int'(rts_pin), 0);
    chk(tx_permit === 1'b1, "R1", "reset tx_permit", int'(tx_permit), 1);
    chk(cts_change === 1'b0, "R1", "reset cts_change", int'(cts_change), 0);
    rst_n = 1'b1;
    step(4);

    tag = "R2"; cfg = 8'h02; step(4); cfg = 8'h00; step(3);
    tag = "R3"; cfg = 8'h12; step(3); cfg = 8'h10; step(3);

    tag = "R4"; cfg = 8'h01; lead_dly = 8'd3; trail_dly = 8'd2;
    burst(8, 3, 8);
    tag = "R6"; lead_dly = 8'd1; trail_dly = 8'd5;
    burst(4, 2, 10);
    tag = "R3"; cfg = 8'h11; burst(6, 1, 8);

    tag = "R5"; cfg = 8'h05; tick_div = 4; lead_dly = 8'd2; trail_dly = 8'd3;
    burst(14, 3, 20);
    tick_div = 0;

    tag = "R7"; cfg = 8'h01; lead_dly = 8'd1; trail_dly = 8'd6;
    burst(3, 1, 2);
    tx_has_data = 1'b1; tx_idle = 1'b0; step(3);
    tx_has_data = 1'b0; tx_idle = 1'b1; step(10);

    tag = "R8"; lead_dly = 8'd0; trail_dly = 8'd0;
    burst(3, 1, 4);

    tag = "R13"; cfg = 8'h09; lead_dly = 8'd1; trail_dly = 8'd2;
    burst(4, 5, 4);
    cfg = 8'h01; burst(4, 5, 6);

    tag = "R9"; cfg = 8'h21; lead_dly = 8'd1; trail_dly = 8'd1;
    tx_has_data = 1'b1; tx_idle = 1'b0; step(3);
    cts_pin = 1'b1; step(5); cts_pin = 1'b0; step(4);
    cfg = 8'h61; step(4); cts_pin = 1'b1; step(4);
    tx_has_data = 1'b0; tx_idle = 1'b1; step(5);
    cfg = 8'h20; step(3); cts_pin = 1'b0; step(4);

    tag = "R10"; cfg = 8'h00;
    for (int k = 0; k < 4; k++) begin
      cts_pin = ~cts_pin; step(3 + k);
    end

    tag = "R11"; cfg = 8'h81; lead_dly = 8'd2; trail_dly = 8'd2;
    step(3); burst(4, 1, 6);

    tag = "R12"; cfg = 8'h01; lead_dly = 8'd6;
    tx_has_data = 1'b1; tx_idle = 1'b0; step(2);
    cfg = 8'h00; step(2);
    cfg = 8'h01; step(3);
    tx_has_data = 1'b0; tx_idle = 1'b1; step(2);
    cfg = 8'h00; step(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule